// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synthesizable model of a synchronous static RAM whose data bus never needs an idle cycle between a read and a write. Every command, address, byte-enable and write-data input is taken on the rising clock edge, and only while the active-low clock enable is low. A load cycle (advance/load strobe low) starts a new operation. An advance cycle (strobe high) continues the current operation at the next word of a four-word burst. A 2-bit counter steps that burst in linear or interleaved order, as a static pin selects.

Write data trails its address by a fixed number of enabled cycles, and read data is returned with the same lag. In pipelined mode the lag is two cycles and in flow-through mode it is one, so reads and writes can be issued back to back. The storage is a small internal array, split into four 9-bit lanes that can each be written on their own. The output-enable pin gates the bus-drive flag without waiting for a clock.

Top module: `zbt_sram_core`

## Requirements
- R1: After reset no operation is active, and `dq_oe` stays low while `oe_n` is low.
- R2: While `cke_n` is high the clock edge has no effect. Outputs hold, the burst position holds, and no load, write or write data is accepted.
- R3: On a load cycle (`adv_ld`=0) with the device selected, `rw`=1 starts a read and `rw`=0 starts a write. On advance cycles `rw` is ignored and the burst keeps its type.
- R4: The device is selected on a load cycle only when `ce0_n`=0, `ce1`=1 and `ce2_n`=0. A deselected load ends any burst, advance cycles after it stay idle, and the chip enables are ignored on advance cycles.
- R5: With `order_sel`=0 (linear), beat k of a burst uses the two low address bits (start + k) mod 4. The upper address bits stay fixed.
- R6: With `order_sel`=1 (interleaved), beat k uses the two low address bits start XOR k. The upper address bits stay fixed.
- R7: `bwe_n[j]`=0 writes data bits 9j+8 down to 9j. The other lanes keep their contents. Byte enables are sampled with each write load and with each write-burst advance.
- R8: With `pipe_sel`=1, the read word for an address taken at enabled edge n is presented after edge n+1. Write data for an address taken at edge n is sampled at edge n+2.
- R9: With `pipe_sel`=0, the read word for an address taken at enabled edge n is presented after edge n, and write data for it is sampled at edge n+1.
- R10: A read issued on the cycle right after a write to the same address returns the newly written data, in both latency modes.
- R11: `dq_oe` is high only while read data for a selected read is being presented and `oe_n` is low. It follows `oe_n` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state (not the array) |
| cke_n | input | 1 | Active-low clock enable |
| addr | input | AW | Word address; the two low bits start the burst |
| ce0_n | input | 1 | Active-low chip enable, sampled on load cycles |
| ce1 | input | 1 | Active-high chip enable, sampled on load cycles |
| ce2_n | input | 1 | Active-low chip enable, sampled on load cycles |
| adv_ld | input | 1 | 0 = load new operation, 1 = advance burst |
| rw | input | 1 | 1 = read, 0 = write, on load cycles |
| bwe_n | input | NL | Active-low per-lane write enables |
| oe_n | input | 1 | Asynchronous active-low output enable |
| order_sel | input | 1 | Static burst order: 1 interleaved, 0 linear |
| pipe_sel | input | 1 | Static latency: 1 pipelined, 0 flow-through |
| din | input | NL*LW | Write data |
| dq_out | output | NL*LW | Read data |
| dq_oe | output | 1 | Bus-drive flag for `dq_out` |

## Verification
The assertions check the per-cycle control rules on every cycle. These are the stall hold, load decoding and chip-select qualification, idle advances after a deselect, the linear step of the low address bits, the read slot following its address in each latency mode, and output-enable gating. The bench's scenarios are the only place where the data path is shown. They cover the interleaved beat order, lane-masked writes landing in the right words, data arriving with the correct lag, same-address forwarding between back-to-back operations, and garbage applied during stalls leaving the array untouched. Those checks need whole sequences and a model of the memory contents.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int BURST_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    typedef enum logic {
        LAT_FLOW = 1'b0,
        LAT_PIPE = 1'b1
    } out_lat_e;

    // Low address bits for a given beat of a four-word burst (R5, R6)
    function automatic logic [BURST_W-1:0] burst_offset(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] beat,
        input burst_order_e       ord
    );
        if (ord == ORD_LINEAR)
            return BURST_W'(start + beat);
        else
            return start ^ beat;
    endfunction

endpackage

// File: rtl/zbt_cmd.sv
// Command capture and burst sequencer: holds the operation that owns the
// current address slot.
module zbt_cmd #(
    parameter int AW = 6,
    parameter int NL = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 adv_ld,
    input  logic                 rw,
    input  logic                 sel,
    input  logic [AW-1:0]        addr,
    input  logic [NL-1:0]        be,
    input  zbt_pkg::burst_order_e ord,
    output logic                 op_vld,
    output logic                 op_wr,
    output logic [AW-1:0]        op_addr,
    output logic [NL-1:0]        op_be
);
    import zbt_pkg::*;

    localparam int HI_W = AW - BURST_W;

    typedef struct packed {
        logic               vld;
        logic               wr;
        logic [AW-1:0]      base;
        logic [BURST_W-1:0] beat;
        logic [NL-1:0]      be;
    } cmd_t;

    cmd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cke) begin
            if (!adv_ld) begin
                // R3/R4: load cycle takes selection, type and start address
                st_d.vld  = sel;
                st_d.wr   = !rw;
                st_d.base = addr;
                st_d.beat = '0;
                st_d.be   = be;
            end else if (st_q.vld) begin
                // advance: type and selection kept, lanes re-sampled (R7)
                st_d.beat = BURST_W'(st_q.beat + 1'b1);
                st_d.be   = be;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [HI_W-1:0] addr_hi;
    assign addr_hi = st_q.base[AW-1:BURST_W];

    assign op_vld  = st_q.vld;
    assign op_wr   = st_q.wr;
    assign op_be   = st_q.be;
    assign op_addr = {addr_hi, burst_offset(st_q.base[BURST_W-1:0], st_q.beat, ord)};

endmodule

// File: rtl/zbt_array.sv
// Lane-split storage: one write port with per-lane enables, one read port.
module zbt_array #(
    parameter int AW = 6,
    parameter int NL = 4,
    parameter int LW = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [NL-1:0]    wbe,
    input  logic [NL*LW-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [NL*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LW-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wbe[g])
                lane_mem[waddr] <= wdata[g*LW +: LW];
        end

        assign rdata[g*LW +: LW] = lane_mem[raddr];
    end

endmodule

// File: rtl/zbt_lat.sv
// Latency stage: picks the write slot for the chosen mode, registers read
// data in pipelined mode and forwards same-address write data.
module zbt_lat #(
    parameter int AW = 6,
    parameter int NL = 4,
    parameter int LW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  zbt_pkg::out_lat_e mode,
    input  logic              op_vld,
    input  logic              op_wr,
    input  logic [AW-1:0]     op_addr,
    input  logic [NL-1:0]     op_be,
    input  logic [NL*LW-1:0]  din,
    input  logic [NL*LW-1:0]  arr_rdata,
    output logic              arr_we,
    output logic [AW-1:0]     arr_waddr,
    output logic [NL-1:0]     arr_wbe,
    output logic [AW-1:0]     arr_raddr,
    output logic [NL*LW-1:0]  dout,
    output logic              rd_active
);
    import zbt_pkg::*;

    localparam int DW = NL * LW;

    typedef struct packed {
        logic          s2_vld;
        logic          s2_wr;
        logic [AW-1:0] s2_addr;
        logic [NL-1:0] s2_be;
        logic          rd_vld;
        logic [DW-1:0] rd_data;
    } lat_t;

    lat_t st_d, st_q;

    logic          is_pipe;
    logic          wr_pipe;
    logic          wr_flow;
    logic          same_addr;
    logic [DW-1:0] fwd_word;

    assign is_pipe = (mode == LAT_PIPE);
    assign wr_pipe = st_q.s2_vld && st_q.s2_wr;
    assign wr_flow = op_vld && op_wr;

    // R8/R9: write slot is two enabled edges after the address when
    // pipelined, one edge after when flow-through
    always_comb begin
        if (is_pipe) begin
            arr_we    = cke && wr_pipe;
            arr_waddr = st_q.s2_addr;
            arr_wbe   = st_q.s2_be;
        end else begin
            arr_we    = cke && wr_flow;
            arr_waddr = op_addr;
            arr_wbe   = op_be;
        end
    end

    assign arr_raddr = op_addr;
    assign same_addr = arr_we && (arr_waddr == op_addr);

    // R10: lanes being written this edge to the read address are forwarded
    for (genvar g = 0; g < NL; g++) begin : g_fwd
        assign fwd_word[g*LW +: LW] = (same_addr && arr_wbe[g])
                                      ? din[g*LW +: LW]
                                      : arr_rdata[g*LW +: LW];
    end

    always_comb begin
        st_d = st_q;
        if (cke) begin
            st_d.s2_vld  = op_vld;
            st_d.s2_wr   = op_wr;
            st_d.s2_addr = op_addr;
            st_d.s2_be   = op_be;
            st_d.rd_vld  = op_vld && !op_wr;
            st_d.rd_data = fwd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout      = is_pipe ? st_q.rd_data : arr_rdata;
    assign rd_active = is_pipe ? st_q.rd_vld  : (op_vld && !op_wr);

endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core #(
    parameter int AW = 6,
    parameter int NL = 4,
    parameter int LW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic [AW-1:0]    addr,
    input  logic             ce0_n,
    input  logic             ce1,
    input  logic             ce2_n,
    input  logic             adv_ld,
    input  logic             rw,
    input  logic [NL-1:0]    bwe_n,
    input  logic             oe_n,
    input  logic             order_sel,
    input  logic             pipe_sel,
    input  logic [NL*LW-1:0] din,
    output logic [NL*LW-1:0] dq_out,
    output logic             dq_oe
);
    import zbt_pkg::*;

    localparam int DW = NL * LW;

    logic          cke;
    logic          sel;
    burst_order_e  ord;
    out_lat_e      mode;

    logic          cur_vld;
    logic          cur_wr;
    logic [AW-1:0] cur_addr;
    logic [NL-1:0] cur_be;

    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [NL-1:0] arr_wbe;
    logic [AW-1:0] arr_raddr;
    logic [DW-1:0] arr_rdata;
    logic          rd_active;

    assign cke  = !cke_n;
    assign sel  = !ce0_n && ce1 && !ce2_n;   // R4
    assign ord  = burst_order_e'(order_sel);
    assign mode = out_lat_e'(pipe_sel);

    zbt_cmd #(.AW(AW), .NL(NL)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cke     (cke),
        .adv_ld  (adv_ld),
        .rw      (rw),
        .sel     (sel),
        .addr    (addr),
        .be      (~bwe_n),
        .ord     (ord),
        .op_vld  (cur_vld),
        .op_wr   (cur_wr),
        .op_addr (cur_addr),
        .op_be   (cur_be)
    );

    zbt_lat #(.AW(AW), .NL(NL), .LW(LW)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .mode      (mode),
        .op_vld    (cur_vld),
        .op_wr     (cur_wr),
        .op_addr   (cur_addr),
        .op_be     (cur_be),
        .din       (din),
        .arr_rdata (arr_rdata),
        .arr_we    (arr_we),
        .arr_waddr (arr_waddr),
        .arr_wbe   (arr_wbe),
        .arr_raddr (arr_raddr),
        .dout      (dq_out),
        .rd_active (rd_active)
    );

    zbt_array #(.AW(AW), .NL(NL), .LW(LW)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wbe   (arr_wbe),
        .wdata (din),
        .raddr (arr_raddr),
        .rdata (arr_rdata)
    );

    // R11: asynchronous output enable
    assign dq_oe = rd_active && !oe_n;

endmodule

// File: rtl/zbt_sram_core_chk.sv
module zbt_sram_core_chk #(
    parameter int AW = 6,
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cke_n,
    input logic          adv_ld,
    input logic          rw,
    input logic          ce0_n,
    input logic          ce1,
    input logic          ce2_n,
    input logic          oe_n,
    input logic          order_sel,
    input logic          pipe_sel,
    input logic          dq_oe,
    input logic [DW-1:0] dq_out,
    input logic          cur_vld,
    input logic          cur_wr,
    input logic [AW-1:0] cur_addr,
    input logic          rd_active
);
    logic chip_on;
    assign chip_on = !ce0_n && ce1 && !ce2_n;

    a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(cur_vld) && $stable(cur_addr) && $stable(rd_active) && $stable(dq_out));

    a_r3_load_type: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && chip_on) |=> cur_vld && (cur_wr == !$past(rw)));

    a_r3_advance_keeps_type: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && cur_vld) |=> cur_vld && $stable(cur_wr));

    a_r4_deselect_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !chip_on) |=> !cur_vld);

    a_r4_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && !cur_vld) |=> !cur_vld);

    a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && cur_vld && !order_sel)
        |=> cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1));

    a_r8_pipe_read_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_sel && !cke_n && cur_vld && !cur_wr) |=> rd_active);

    a_r9_flow_read_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_sel && !cke_n && !adv_ld && chip_on && rw) |=> rd_active);

    a_r11_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

endmodule

bind zbt_sram_core zbt_sram_core_chk #(.AW(AW), .DW(NL*LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_n     (cke_n),
    .adv_ld    (adv_ld),
    .rw        (rw),
    .ce0_n     (ce0_n),
    .ce1       (ce1),
    .ce2_n     (ce2_n),
    .oe_n      (oe_n),
    .order_sel (order_sel),
    .pipe_sel  (pipe_sel),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out),
    .cur_vld   (cur_vld),
    .cur_wr    (cur_wr),
    .cur_addr  (cur_addr),
    .rd_active (rd_active)
);

// File: tb/zbt_sram_core_test.sv
`timescale 1ns/1ps
module zbt_sram_core_test;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam int DEPTH = 1 << AW;
    localparam int GROUPS = DEPTH / 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cke_n;
    logic [AW-1:0] addr;
    logic          ce0_n, ce1, ce2_n;
    logic          adv_ld, rw;
    logic [NL-1:0] bwe_n;
    logic          oe_n;
    logic          order_sel, pipe_sel;
    logic [DW-1:0] din;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    always #4 clk = ~clk;

    zbt_sram_core #(.AW(AW), .NL(NL), .LW(LW)) uut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .addr(addr),
        .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .adv_ld(adv_ld), .rw(rw),
        .bwe_n(bwe_n), .oe_n(oe_n), .order_sel(order_sel), .pipe_sel(pipe_sel),
        .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    logic [DW-1:0] ref_mem [DEPTH];
    int n_checks = 0;
    int n_fail   = 0;
    int lat      = 2;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input logic adv, input logic r, input logic [AW-1:0] a,
                         input logic s, input logic [NL-1:0] ben, input logic [DW-1:0] d);
        cke_n = 1'b0; adv_ld = adv; rw = r; addr = a;
        ce0_n = !s; ce1 = s; ce2_n = !s; bwe_n = ben; din = d;
    endtask

    task automatic nop();
        drive(1'b0, 1'b1, '0, 1'b0, '1, '0);
    endtask

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base, input int k, input logic ord);
        logic [1:0] lo;
        lo = ord ? (base[1:0] ^ 2'(k)) : 2'(base[1:0] + 2'(k));
        return {base[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] lane_mask(input logic [NL-1:0] ben);
        logic [DW-1:0] m = '0;
        for (int j = 0; j < NL; j++)
            if (!ben[j]) m[j*LW +: LW] = '1;
        return m;
    endfunction

    function automatic logic [DW-1:0] pat(input int x);
        logic [31:0] v;
        v = 32'(x) * 32'h9E3779B1 ^ 32'h5A5A0F0F;
        return {4'(x + 3), v};
    endfunction

    // Write burst; advance cycles drive rw=1 and deselect to show both are ignored (R3, R4)
    task automatic write_burst(input logic [AW-1:0] base, input logic ord, input int seed, input bit partial);
        logic [NL-1:0] ben [4];
        logic [AW-1:0] wa;
        logic [DW-1:0] d;
        order_sel = ord;
        for (int i = 0; i <= 3 + lat; i++) begin
            d = '0;
            if (i < 4) ben[i] = partial ? 4'(seed + i * 5) : '0;
            if (i >= lat && i - lat < 4) begin
                d  = pat(seed + i - lat);
                wa = beat_addr(base, i - lat, ord);
                ref_mem[wa] = (ref_mem[wa] & ~lane_mask(ben[i - lat])) | (d & lane_mask(ben[i - lat]));
            end
            if (i == 0)      drive(1'b0, 1'b0, base, 1'b1, ben[0], d);
            else if (i < 4)  drive(1'b1, 1'b1, ~base, 1'b0, ben[i], d);
            else begin       nop(); din = d; end
            tick();
        end
    endtask

    // Read burst with optional stall before cycle stall_at; advance cycles drive rw=0, deselect
    task automatic read_burst(input logic [AW-1:0] base, input logic ord, input int stall_at, input string tag);
        int k;
        logic [DW-1:0] o_hold;
        logic          e_hold;
        order_sel = ord;
        for (int i = 0; i <= 3 + lat; i++) begin
            if (i == stall_at) begin
                o_hold = dq_out; e_hold = dq_oe;
                for (int s = 0; s < 3; s++) begin
                    drive(1'b0, 1'b0, base, 1'b1, '0, pat(777 + s));
                    cke_n = 1'b1;
                    tick();
                    chk("R2 stall data", dq_out, o_hold);
                    chk("R2 stall oe", DW'(dq_oe), DW'(e_hold));
                end
            end
            if (i == 0)     drive(1'b0, 1'b1, base, 1'b1, '1, '0);
            else if (i < 4) drive(1'b1, 1'b0, ~base, 1'b0, '0, pat(555));
            else            nop();
            tick();
            k = i - (lat - 1);
            if (k >= 0 && k < 4) begin
                chk({tag, (pipe_sel ? " R8" : " R9"), " oe"}, DW'(dq_oe), DW'(1));
                chk({tag, (ord ? " R6" : " R5"), " data"}, dq_out, ref_mem[beat_addr(base, k, ord)]);
            end else if (k >= 4) begin
                chk({tag, " R4 idle after burst"}, DW'(dq_oe), DW'(0));
            end
        end
    endtask

    task automatic do_reset();
        nop();
        rst_n = 1'b0;
        repeat (2) tick();
        chk("R1 reset oe", DW'(dq_oe), DW'(0));
        rst_n = 1'b1;
        tick();
        chk("R1 idle after reset", DW'(dq_oe), DW'(0));
    endtask

    initial begin
        rst_n = 1'b0; oe_n = 1'b0; order_sel = 1'b1; pipe_sel = 1'b1;
        nop();
        for (int m = 1; m >= 0; m--) begin
            pipe_sel = m[0];
            lat = m ? 2 : 1;
            do_reset();
            for (int o = 0; o < 2; o++) begin
                // full-word fill, then read back in the opposite order
                for (int g = 0; g < GROUPS; g++)
                    write_burst(AW'(g * 4 + (g % 4)), o[0], g * 4 + o * 100 + m * 1000, 1'b0);
                for (int g = 0; g < GROUPS; g++)
                    read_burst(AW'(g * 4 + ((g + 1) % 4)), !o[0], (g == 3) ? 2 : ((g == 7) ? 1 : -1), "R3");
                // lane-masked writes, read back in the same order
                for (int g = 0; g < GROUPS; g += 2)
                    write_burst(AW'(g * 4 + ((g + 2) % 4)), o[0], g + 300 + o * 50 + m * 900, 1'b1);
                for (int g = 0; g < GROUPS; g++)
                    read_burst(AW'(g * 4 + (g % 4)), o[0], -1, "R7");
            end

            // R10: write then read of same address on the next cycle
            begin
                logic [AW-1:0] a10 = AW'(41);
                logic [DW-1:0] d10 = pat(4242 + m);
                for (int t = 0; t <= lat; t++) begin
                    if (t == 0)      drive(1'b0, 1'b0, a10, 1'b1, '0, '0);
                    else if (t == 1) drive(1'b0, 1'b1, a10, 1'b1, '1, '0);
                    else             nop();
                    if (t == lat) begin din = d10; ref_mem[a10] = d10; end
                    tick();
                    if (t == lat) begin
                        chk("R10 forwarded oe", DW'(dq_oe), DW'(1));
                        chk("R10 forwarded data", dq_out, d10);
                        oe_n = 1'b1; #1;
                        chk("R11 oe_n high", DW'(dq_oe), DW'(0));
                        oe_n = 1'b0; #1;
                        chk("R11 oe_n low", DW'(dq_oe), DW'(1));
                    end
                end
                nop();
                repeat (3) tick();
            end

            // R4: each enable alone blocks selection
            for (int v = 0; v < 3; v++) begin
                drive(1'b0, 1'b1, AW'(9), 1'b1, '1, '0);
                if (v == 0) ce0_n = 1'b1;
                if (v == 1) ce1   = 1'b0;
                if (v == 2) ce2_n = 1'b1;
                tick();
                if (lat == 2) begin drive(1'b1, 1'b1, '0, 1'b1, '1, '0); tick(); end
                chk("R4 single enable off", DW'(dq_oe), DW'(0));
                nop(); repeat (2) tick();
            end

            // R4: deselected load ends a read burst; advances after it stay idle
            for (int i = 0; i < 5; i++) begin
                int k;
                if (i == 0)      drive(1'b0, 1'b1, AW'(20), 1'b1, '1, '0);
                else if (i == 2) drive(1'b0, 1'b1, AW'(20), 1'b0, '1, '0);
                else             drive(1'b1, 1'b1, AW'(20), 1'b1, '1, '0);
                tick();
                k = i - (lat - 1);
                if (k >= 0)
                    chk("R4 burst ended by deselect", DW'(dq_oe), DW'(k < 2));
            end
            nop(); repeat (3) tick();
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule